// File: doc/BRIEF.md
# Signed Dot-Product Accumulator Sequencer

This block walks two arrays of signed 16-bit elements held in a byte-addressed memory and forms the sum of their pairwise products in a 32-bit accumulator. A single start pulse gives it three values: the byte address of the first X element, the byte address of the first Y element and the number of pairs. The block then reads X and Y elements in turn through one synchronous read port. Each read returns its data one cycle after the request. Both pointers advance by two bytes after each element fetch. Each pair is multiplied as signed 16x16 and the product is added to the running sum.

Iteration is governed by a decrement-and-branch loop counter. The counter is preloaded with the pair count minus one and is decremented after each accumulate. The run ends on the accumulate in which the counter steps from zero to minus one. A one-cycle done pulse then marks the end of the run. The sum output keeps the final value until the next accepted start.

The controller has five states:
- IDLE: waiting for start.
- FETCH_X: request the X element.
- FETCH_Y: request the Y element and capture the returned X.
- ACCUM: multiply-add with the returned Y and step the counter.
- FINISH: done pulse.

Its transitions are:
- IDLE to FETCH_X on a start with a non-zero count.
- IDLE to FINISH on a start with a zero count.
- FETCH_X to FETCH_Y, always.
- FETCH_Y to ACCUM, always.
- ACCUM to FETCH_X while the counter has not reached zero.
- ACCUM to FINISH on the last pair.
- FINISH to IDLE, always.

Top module: `dotacc_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it, busy_o, done_o and rd_en_o are 0 and sum_o is 0.
- R2: A start accepted in IDLE loads both base addresses and the count, and clears the sum: sum_o reads 0 in the cycle after the start edge.
- R3: For pair i (counting from 0), the block issues a read at x_base_i+2i. It issues a read at y_base_i+2i in the next cycle. The pairs follow at a pace of one every three cycles, and rd_en_o is high only in those two cycles of each pair.
- R4: Each pair is multiplied as signed 16-bit by signed 16-bit, and the 32-bit product is added to the sum. Read data is taken one cycle after its request.
- R5: The loop counter is preloaded with count_i-1 and is decremented after every accumulate. The run ends when it passes below zero, so exactly count_i pairs are read (2*count_i reads). A count_i of 0 makes no reads and ends with a sum of 0.
- R6: done_o is high for exactly one cycle. That cycle is the (3*count_i+1)-th cycle after the start edge, and busy_o is low in the cycle that follows it.
- R7: After done_o, sum_o keeps the final sum unchanged until the next accepted start.
- R8: A start that arrives while busy_o is high, including the done cycle, is ignored. The run's reads, sum and timing are unchanged, and no new run begins.
- R9: Overflow of the sum wraps modulo 2^32 and never saturates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| x_base_i | input | ADDR_W (24) | Byte address of the first X element |
| y_base_i | input | ADDR_W (24) | Byte address of the first Y element |
| count_i | input | CNT_W (16) | Number of element pairs |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | ADDR_W (24) | Memory read byte address |
| rd_data_i | input | DATA_W (16) | Read data, valid one cycle after the request |
| busy_o | output | 1 | High from the start edge through the done cycle |
| done_o | output | 1 | One-cycle end-of-run pulse |
| sum_o | output | ACC_W (32) | Accumulated sum, held after done |

## Verification
The hardest condition to reach from the ports is a wrap of the accumulator. A single signed 16x16 product never reaches 2^32, so the stimulus fills both arrays with the most negative value. Four such products then sum exactly to 2^32 and wrap to zero, and a fifth must leave 2^30. The other hard case is a start that lands on the done cycle itself, where busy_o is high for only one more cycle. The bench places extra start pulses at a chosen cycle offset within a run, including that last busy cycle, and then confirms that no second run begins.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH_X = 3'd1,
        ST_FETCH_Y = 3'd2,
        ST_ACCUM   = 3'd3,
        ST_FINISH  = 3'd4
    } dot_state_e;
endpackage

// File: rtl/dotacc_ptr.sv
// Byte pointer with postincrement step.
module dotacc_ptr #(
    parameter int ADDR_W = 24,
    parameter int STEP   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              adv_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_i) begin
            addr_q <= base_i;
        end else if (adv_i) begin
            addr_q <= addr_q + STEP_V;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/dotacc_loopcnt.sv
// Decrement-and-branch counter: preload count-1, last pass when it is zero.
module dotacc_loopcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dec_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= count_i - CNT_W'(1);
        end else if (dec_i) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Decrementing from zero yields -1, which ends the loop.
    assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dotacc_mac.sv
// Holds X operand, multiplies signed with incoming Y and accumulates.
module dotacc_mac #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              cap_x_i,
    input  logic              acc_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ACC_W-1:0]  sum_o
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [DATA_W-1:0] x_q;
    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  sum_q;

    assign prod = x_q * $signed(data_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
        end else if (cap_x_i) begin
            x_q <= $signed(data_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (clear_i) begin
            sum_q <= '0;
        end else if (acc_i) begin
            sum_q <= sum_q + ACC_W'(prod);
        end
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/dotacc_seq.sv
module dotacc_seq
    import dotacc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] x_base_i,
    input  logic [ADDR_W-1:0] y_base_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ACC_W-1:0]  sum_o
);
    localparam int ELEM_BYTES = DATA_W / 8;
    localparam int N_PTR      = 2;

    dot_state_e state_q, state_d;

    logic              accept;
    logic              adv_x, adv_y, cap_x, do_acc, last;
    logic [ADDR_W-1:0] ptr_addr [N_PTR];
    logic [ADDR_W-1:0] ptr_base [N_PTR];
    logic              ptr_adv  [N_PTR];

    assign accept      = start_i && (state_q == ST_IDLE);
    assign ptr_base[0] = x_base_i;
    assign ptr_base[1] = y_base_i;
    assign ptr_adv[0]  = adv_x;
    assign ptr_adv[1]  = adv_y;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = (count_i == '0) ? ST_FINISH : ST_FETCH_X;
                end
            end
            ST_FETCH_X: state_d = ST_FETCH_Y;
            ST_FETCH_Y: state_d = ST_ACCUM;
            ST_ACCUM:   state_d = last ? ST_FINISH : ST_FETCH_X;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        rd_en_o   = 1'b0;
        rd_addr_o = ptr_addr[0];
        adv_x     = 1'b0;
        adv_y     = 1'b0;
        cap_x     = 1'b0;
        do_acc    = 1'b0;
        busy_o    = 1'b1;
        done_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: busy_o = 1'b0;
            ST_FETCH_X: begin
                rd_en_o   = 1'b1;
                rd_addr_o = ptr_addr[0];
                adv_x     = 1'b1;
            end
            ST_FETCH_Y: begin
                rd_en_o   = 1'b1;
                rd_addr_o = ptr_addr[1];
                adv_y     = 1'b1;
                cap_x     = 1'b1;
            end
            ST_ACCUM:  do_acc = 1'b1;
            ST_FINISH: done_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        dotacc_ptr #(
            .ADDR_W (ADDR_W),
            .STEP   (ELEM_BYTES)
        ) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (accept),
            .base_i (ptr_base[g]),
            .adv_i  (ptr_adv[g]),
            .addr_o (ptr_addr[g])
        );
    end

    dotacc_loopcnt #(
        .CNT_W (CNT_W)
    ) u_loop (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .count_i (count_i),
        .dec_i   (do_acc),
        .last_o  (last)
    );

    dotacc_mac #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .cap_x_i (cap_x),
        .acc_i   (do_acc),
        .data_i  (rd_data_i),
        .sum_o   (sum_o)
    );
endmodule

// File: rtl/dotacc_chk.sv
module dotacc_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic             rd_en_o,
    input logic [ACC_W-1:0] sum_o
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R6

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o); // R3

    AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (sum_o == '0)); // R2

    AST_SUM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(sum_o)); // R7

    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R8
endmodule

bind dotacc_seq dotacc_chk #(.ACC_W(ACC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rd_en_o (rd_en_o),
    .sum_o   (sum_o)
);

// File: tb/dotacc_seq_tb.sv
module dotacc_seq_tb;
    localparam int DW = 16, AW = 32, ADW = 24, CW = 16;
    localparam int YOFF = 128; // Y array word offset

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [ADW-1:0] x_base = '0, y_base = '0;
    logic [CW-1:0]  count = '0;
    logic           rd_en;
    logic [ADW-1:0] rd_addr;
    logic [DW-1:0]  rd_data;
    logic           busy, done;
    logic [AW-1:0]  sum;

    logic signed [DW-1:0] mem [256];

    int checks = 0, fails = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;

    dotacc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .x_base_i(x_base), .y_base_i(y_base), .count_i(count),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .busy_o(busy), .done_o(done), .sum_o(sum)
    );

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr[8:1]];
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] expect_sum(input int n);
        longint a = 0;
        for (int i = 0; i < n; i++) a += longint'(mem[i]) * longint'(mem[YOFF + i]);
        return a[AW-1:0];
    endfunction

    // glitch_k: cycle after the start edge in which an extra start is driven (0 = none)
    task automatic run(input int n, input int glitch_k, input string tag);
        int k, reads, bad_addr, lat;
        logic [AW-1:0] exp_s;
        exp_s = expect_sum(n);
        @(negedge clk);
        start = 1'b1; x_base = 24'd0; y_base = 24'(YOFF * 2); count = CW'(n);
        @(negedge clk);
        start = 1'b0;
        k = 1; reads = 0; bad_addr = 0; lat = -1;
        chk(sum == '0, {"R2 sum cleared ", tag}, sum, 0);
        while (k <= 3 * n + 4) begin
            if (rd_en) begin
                if (rd_addr != ((reads % 2 == 0) ? ADW'(2 * (reads / 2))
                                                : ADW'(YOFF * 2 + 2 * (reads / 2)))) bad_addr++;
                reads++;
            end
            if (done && lat < 0) begin
                lat = k;
                chk(sum == exp_s, {"R4 R5 sum ", tag}, sum, exp_s);
            end
            if (glitch_k != 0 && k == glitch_k) begin
                start = 1'b1; x_base = 24'h40; y_base = 24'h60; count = 16'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(lat == 3 * n + 1, {"R6 done latency ", tag}, lat, 3 * n + 1);
        chk(reads == 2 * n && bad_addr == 0, {"R3 R5 read sequence ", tag}, reads, 2 * n);
        chk(!busy && !done, {"R6 R8 idle after run ", tag}, busy, 0);
        chk(sum == exp_s, {"R7 sum held ", tag}, sum, exp_s);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !rd_en && sum == '0, "R1 state in reset", {busy, done, rd_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !rd_en, "R1 flags after reset", {busy, done, rd_en}, 0);
        chk(sum == '0, "R1 sum after reset", sum, 0);

        // Sweep counts 0..8 with mixed-sign patterns
        for (int n = 0; n <= 8; n++) begin
            for (int i = 0; i < 16; i++) begin
                mem[i]        = DW'((i * 4099 + n * 311) % 65536);
                mem[YOFF + i] = DW'((65536 - i * 2731 - n * 97) % 65536);
            end
            run(n, 0, $sformatf("sweep n=%0d", n));
        end

        // Corner operand grid: all pairs of extremes (R4)
        begin
            logic signed [DW-1:0] cv [4] = '{16'sh8000, -16'sd1, 16'sd0, 16'sh7FFF};
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    mem[a * 4 + b]        = cv[a];
                    mem[YOFF + a * 4 + b] = cv[b];
                end
            run(16, 0, "extreme grid");
        end

        // Overflow wrap (R9): four products of 2^30 wrap to 0, five give 2^30
        for (int i = 0; i < 8; i++) begin
            mem[i] = 16'sh8000; mem[YOFF + i] = 16'sh8000;
        end
        run(4, 0, "R9 wrap to zero");
        chk(sum == 32'h0, "R9 wrapped sum", sum, 0);
        run(5, 0, "R9 wrap plus one");
        chk(sum == 32'h4000_0000, "R9 wrapped sum", sum, 32'h4000_0000);

        // Start while busy (R8): mid-run and on the done cycle
        for (int i = 0; i < 16; i++) begin
            mem[i] = DW'(i * 37 - 200); mem[YOFF + i] = DW'(300 - i * 53);
        end
        run(6, 5, "R8 mid-run start");
        run(6, 19, "R8 start on done cycle");

        // Hold after done (R7)
        repeat (7) @(negedge clk);
        chk(sum == expect_sum(6) && !busy, "R7 long hold", sum, expect_sum(6));

        // Default-size run: 100 pairs, counter preload 99 (R5)
        for (int i = 0; i < 100; i++) begin
            mem[i] = DW'(i * 331 - 16000); mem[YOFF + i] = DW'(12000 - i * 241);
        end
        run(100, 0, "R5 hundred pairs");

        if (!wd_hit) begin
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule